// File: doc/BRIEF.md
# Far-End Alarm Code Word Channel

This block carries far-end alarm and control code words over a single overhead bit per frame. A frame strobe marks each overhead-bit slot; on every strobe the block takes one received bit and hands one transmit bit to the framer. The channel is active only while the C-bit parity format is selected. In the other format it sends all ones and ignores what it receives.

On the transmit side, a host loads a 6-bit code and then raises an execute control. The block sends a 16-bit word and keeps sending it while execute stays high. The word is a 0 bit, then code bits d5 down to d0, then a 0 bit, then eight 1 bits. When execute is dropped, the word in flight completes and the line returns to all ones. A code load is refused while execute is high or a word is still on the line. So the host must end a transmission before it can change the code.

On the receive side, the block hunts the bit stream for framed words. It declares a new code only after five identical words arrive back to back. The declaration gives a one-cycle new-code pulse and updates a held code register. An idle flag reports a run of at least sixteen consecutive ones, and it drops on the first 0 received.

Top module: `feac_chan`

## Requirements
- R1: After reset, tx_bit is 1, tx_active is 0, rx_code is 0, rx_new is 0 and rx_idle is 0.
- R2: With host_exec high at a strobe while idle, tx_active rises and the next 16 strobes carry the word bit by bit. The order is 0, code bit 5 down to code bit 0, 0, and then eight 1s.
- R3: While host_exec stays high, words follow one another with no gap. After host_exec falls, the current word completes and the next strobe carries a 1 with tx_active low.
- R4: When no word is being sent, tx_bit is 1 at every strobe.
- R5: A host_load pulse changes the transmitted code only when host_exec is low and tx_active is low. Otherwise it has no effect.
- R6: A received code is declared only on the last bit of the fifth consecutive identical word. At that point rx_new pulses for one cycle and rx_code takes the code. Four words are not enough.
- R7: A word whose code differs from the previous one restarts the repetition count at 1. So does a word that does not follow the previous one exactly 16 strobes later.
- R8: Further repeats of an already declared code, back to back, do not pulse rx_new again.
- R9: rx_idle rises on the sixteenth consecutive received 1 and clears on the strobe that receives a 0.
- R10: With cbit_mode low, tx_bit is 1 and tx_active goes low on the next cycle, even in mid-word. The receiver declares nothing, leaves rx_code unchanged and holds rx_idle low.
- R11: rx_code holds its value between declarations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cbit_mode | input | 1 | 1 = C-bit parity format, channel active |
| frame_stb | input | 1 | One-cycle pulse per overhead-bit slot |
| host_code | input | 6 | Code to load for transmission |
| host_load | input | 1 | Load pulse for host_code |
| host_exec | input | 1 | Execute control: send while high |
| tx_bit | output | 1 | Overhead bit taken at the next strobe |
| tx_active | output | 1 | A word is being sent |
| rx_bit | input | 1 | Received overhead bit, valid at the strobe |
| rx_code | output | 6 | Last declared received code |
| rx_new | output | 1 | One-cycle pulse when a code is declared |
| rx_idle | output | 1 | All-ones run of sixteen or more present |

## Verification
Some properties are checked on every cycle:
- The idle line carries ones, and each sent word starts with a zero.
- Mode-off forces the sender idle.
- The loaded code is frozen while a transmission is pending or running.
- The repetition count never exceeds five, and a declaration only occurs at full count.
- rx_code changes only with a declaration.
- A received 0 clears the idle flag.

Other behaviour only the directed scenarios can show:
- The bit-exact word order, and that a word completes after execute falls.
- Which exact word in a sequence triggers a declaration.
- That a changed code or a one-slot gap restarts the count.
- That the idle flag rises on exactly the sixteenth one.

// File: rtl/feac_pkg.sv
// Shared constants and types for the far-end alarm code word channel.
package feac_pkg;
    localparam int FEAC_CODE_W   = 6;   // variable code field width
    localparam int FEAC_TAIL_W   = 8;   // trailing ones after the closing zero
    localparam int FEAC_REPS     = 5;   // identical words needed to declare
    localparam int FEAC_IDLE_RUN = 16;  // consecutive ones that mean idle

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } feac_tx_state_e;
endpackage

// File: rtl/feac_tx.sv
// Transmit sequencer: holds the host code and shifts out framed words,
// one bit per strobe, while execute is high. Assumes the strobe is a
// single-cycle pulse. tx_bit always holds the bit consumed at the next strobe.
module feac_tx
    import feac_pkg::*;
#(
    parameter int CODE_W = FEAC_CODE_W,
    parameter int TAIL_W = FEAC_TAIL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_on,
    input  logic              bit_stb,
    input  logic              exec,
    input  logic              host_load,
    input  logic [CODE_W-1:0] host_code,
    output logic              tx_bit,
    output logic              tx_active
);
    localparam int WORD_W = CODE_W + 2 + TAIL_W;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] IDX_ZERO = '0;

    feac_tx_state_e    state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CODE_W-1:0] code_q;
    logic              bit_q;

    // Bit k of a framed word: zero, code MSB first, zero, then ones.
    function automatic logic word_bit(input logic [CODE_W-1:0] c,
                                      input logic [IDX_W-1:0]  k);
        int ki;
        logic [CODE_W-1:0] sh;
        ki = int'(k);
        sh = c << (ki - 1);
        if (ki == 0 || ki == CODE_W + 1) return 1'b0;
        if (ki <= CODE_W)                return sh[CODE_W-1];
        return 1'b1;
    endfunction

    // Code register: loads only when no transmission is pending or running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_q <= '0;
        else if (host_load && !exec && state_q == TX_IDLE)
            code_q <= host_code;
    end

    // Word sequencer: start, advance, repeat or stop at the word boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_on) begin
            state_q <= TX_IDLE;
            idx_q   <= IDX_ZERO;
            bit_q   <= 1'b1;
        end else if (bit_stb) begin
            case (state_q)
                TX_IDLE: begin
                    if (exec) begin
                        state_q <= TX_SEND;
                        idx_q   <= IDX_ZERO;
                        bit_q   <= word_bit(code_q, IDX_ZERO);
                    end
                end
                TX_SEND: begin
                    if (idx_q == LAST_IDX) begin
                        idx_q <= IDX_ZERO;
                        if (exec) begin
                            bit_q <= word_bit(code_q, IDX_ZERO);
                        end else begin
                            state_q <= TX_IDLE;
                            bit_q   <= 1'b1;
                        end
                    end else begin
                        idx_q <= idx_q + 1'b1;
                        bit_q <= word_bit(code_q, idx_q + 1'b1);
                    end
                end
                default: begin
                    state_q <= TX_IDLE;
                    bit_q   <= 1'b1;
                end
            endcase
        end
    end

    assign tx_bit    = bit_q;
    assign tx_active = (state_q == TX_SEND);

    // R4: an idle sender drives ones
    a_r4_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_IDLE) |-> bit_q);
    // R2: every word opens with a zero
    a_r2_open_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SEND && idx_q == IDX_ZERO) |-> !bit_q);
    // R10: mode off stops the sender on the next cycle
    a_r10_mode_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> (state_q == TX_IDLE));
    // R5: code frozen while a transmission is pending or running
    a_r5_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (exec || state_q == TX_SEND) |=> $stable(code_q));
endmodule

// File: rtl/feac_rx_align.sv
// Receive word aligner: shifts in one bit per strobe and flags a complete
// framed word (zero, six code bits, zero, eight ones) ending on this strobe.
// The hit output is combinational and valid only in the strobe cycle.
module feac_rx_align
    import feac_pkg::*;
#(
    parameter int CODE_W = FEAC_CODE_W,
    parameter int TAIL_W = FEAC_TAIL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_on,
    input  logic              bit_stb,
    input  logic              rx_bit,
    output logic              hit,
    output logic [CODE_W-1:0] hit_code
);
    localparam int WORD_W = CODE_W + 2 + TAIL_W;

    logic [WORD_W-1:0] sr_q;
    logic [WORD_W-1:0] sr_nxt;

    // Window including the bit arriving now; oldest bit at the top.
    always_comb begin
        sr_nxt   = {sr_q[WORD_W-2:0], rx_bit};
        hit_code = sr_nxt[WORD_W-2 -: CODE_W];
        hit      = bit_stb && mode_on && !sr_nxt[WORD_W-1]
                   && !sr_nxt[TAIL_W] && (&sr_nxt[TAIL_W-1:0]);
    end

    // Shift register: filled with ones when inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_on)
            sr_q <= '1;
        else if (bit_stb)
            sr_q <= sr_nxt;
    end
endmodule

// File: rtl/feac_rx_persist.sv
// Repetition validator: counts identical back-to-back words and declares a
// code on the word that completes the required run. Back-to-back means the
// next word ends exactly one word length of strobes after the previous one.
module feac_rx_persist
    import feac_pkg::*;
#(
    parameter int CODE_W = FEAC_CODE_W,
    parameter int TAIL_W = FEAC_TAIL_W,
    parameter int REPS   = FEAC_REPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_on,
    input  logic              bit_stb,
    input  logic              hit,
    input  logic [CODE_W-1:0] hit_code,
    output logic              new_pulse,
    output logic [CODE_W-1:0] code
);
    localparam int WORD_W  = CODE_W + 2 + TAIL_W;
    localparam int REP_W   = $clog2(REPS + 1);
    localparam int SINCE_W = $clog2(WORD_W + 1);
    localparam logic [SINCE_W-1:0] SINCE_SAT = SINCE_W'(WORD_W);
    localparam logic [SINCE_W-1:0] SINCE_ADJ = SINCE_W'(WORD_W - 1);
    localparam logic [REP_W-1:0]   REP_FULL  = REP_W'(REPS);
    localparam logic [REP_W-1:0]   REP_ONE   = REP_W'(1);

    logic [SINCE_W-1:0] since_q;
    logic [REP_W-1:0]   rep_q;
    logic [REP_W-1:0]   rep_nxt;
    logic [CODE_W-1:0]  prev_q;
    logic [CODE_W-1:0]  code_q;
    logic               new_q;
    logic               cont;
    logic               declare;

    // Run continuation and declaration decision for the current hit.
    always_comb begin
        cont = (since_q == SINCE_ADJ) && (hit_code == prev_q);
        if (!cont)
            rep_nxt = REP_ONE;
        else if (rep_q == REP_FULL)
            rep_nxt = REP_FULL;
        else
            rep_nxt = rep_q + 1'b1;
        declare = hit && (rep_nxt == REP_FULL) && !(cont && rep_q == REP_FULL);
    end

    // Run counter, spacing counter and declared-code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= SINCE_SAT;
            rep_q   <= '0;
            prev_q  <= '0;
            code_q  <= '0;
            new_q   <= 1'b0;
        end else begin
            new_q <= 1'b0;
            if (!mode_on) begin
                since_q <= SINCE_SAT;
                rep_q   <= '0;
            end else if (hit) begin
                since_q <= '0;
                rep_q   <= rep_nxt;
                prev_q  <= hit_code;
                if (declare) begin
                    new_q  <= 1'b1;
                    code_q <= hit_code;
                end
            end else if (bit_stb && since_q != SINCE_SAT) begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    assign new_pulse = new_q;
    assign code      = code_q;

    // R8: run counter never exceeds the required count
    a_r8_rep_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= REP_FULL);
    // R6: a declaration follows a strobe and a full run
    a_r6_new_on_full: assert property (@(posedge clk) disable iff (!rst_n)
        new_q |-> (rep_q == REP_FULL && $past(bit_stb)));
    // R11: the held code changes only with a declaration
    a_r11_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !new_q |-> $stable(code_q));
    // R10: nothing is declared while inactive
    a_r10_no_decl: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> !new_q);
endmodule

// File: rtl/feac_rx_idle.sv
// Idle detector: counts consecutive received ones, saturating at the idle
// run length. The flag is set when the run is reached and dropped on any 0.
module feac_rx_idle
    import feac_pkg::*;
#(
    parameter int IDLE_RUN = FEAC_IDLE_RUN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_on,
    input  logic bit_stb,
    input  logic rx_bit,
    output logic idle
);
    localparam int RUN_W = $clog2(IDLE_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(IDLE_RUN);
    localparam logic [RUN_W-1:0] RUN_M1   = RUN_W'(IDLE_RUN - 1);

    logic [RUN_W-1:0] run_q;
    logic             idle_q;

    // Ones-run counter and idle flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !mode_on) begin
            run_q  <= '0;
            idle_q <= 1'b0;
        end else if (bit_stb) begin
            if (rx_bit) begin
                if (run_q != RUN_FULL) run_q <= run_q + 1'b1;
                if (run_q >= RUN_M1)   idle_q <= 1'b1;
            end else begin
                run_q  <= '0;
                idle_q <= 1'b0;
            end
        end
    end

    assign idle = idle_q;

    // R9: a received zero clears the flag
    a_r9_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && mode_on && !rx_bit) |=> !idle_q);
    // R9: the flag is only up with a full run of ones
    a_r9_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        idle_q |-> (run_q == RUN_FULL));
endmodule

// File: rtl/feac_chan.sv
// Far-end alarm code word channel: transmit sequencer plus receive aligner,
// repetition validator and idle detector, sharing the frame strobe.
// Assumes frame_stb is one cycle wide and rx_bit is valid with it.
module feac_chan
    import feac_pkg::*;
#(
    parameter int CODE_W   = FEAC_CODE_W,
    parameter int TAIL_W   = FEAC_TAIL_W,
    parameter int REPS     = FEAC_REPS,
    parameter int IDLE_RUN = FEAC_IDLE_RUN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cbit_mode,
    input  logic              frame_stb,
    input  logic [CODE_W-1:0] host_code,
    input  logic              host_load,
    input  logic              host_exec,
    output logic              tx_bit,
    output logic              tx_active,
    input  logic              rx_bit,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_new,
    output logic              rx_idle
);
    logic              hit;
    logic [CODE_W-1:0] hit_code;

    feac_tx #(.CODE_W(CODE_W), .TAIL_W(TAIL_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .mode_on(cbit_mode), .bit_stb(frame_stb),
        .exec(host_exec), .host_load(host_load), .host_code(host_code),
        .tx_bit(tx_bit), .tx_active(tx_active)
    );

    feac_rx_align #(.CODE_W(CODE_W), .TAIL_W(TAIL_W)) u_align (
        .clk(clk), .rst_n(rst_n), .mode_on(cbit_mode), .bit_stb(frame_stb),
        .rx_bit(rx_bit), .hit(hit), .hit_code(hit_code)
    );

    feac_rx_persist #(.CODE_W(CODE_W), .TAIL_W(TAIL_W), .REPS(REPS)) u_persist (
        .clk(clk), .rst_n(rst_n), .mode_on(cbit_mode), .bit_stb(frame_stb),
        .hit(hit), .hit_code(hit_code), .new_pulse(rx_new), .code(rx_code)
    );

    feac_rx_idle #(.IDLE_RUN(IDLE_RUN)) u_idle (
        .clk(clk), .rst_n(rst_n), .mode_on(cbit_mode), .bit_stb(frame_stb),
        .rx_bit(rx_bit), .idle(rx_idle)
    );
endmodule

// File: tb/feac_chan_tb.sv
module feac_chan_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cbit_mode = 1'b1;
    logic       frame_stb = 1'b0;
    logic [5:0] host_code = '0;
    logic       host_load = 1'b0;
    logic       host_exec = 1'b0;
    logic       tx_bit;
    logic       tx_active;
    logic       rx_bit = 1'b1;
    logic [5:0] rx_code;
    logic       rx_new;
    logic       rx_idle;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    always #(CLK_P/2) clk = ~clk;

    feac_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cbit_mode(cbit_mode), .frame_stb(frame_stb),
        .host_code(host_code), .host_load(host_load), .host_exec(host_exec),
        .tx_bit(tx_bit), .tx_active(tx_active), .rx_bit(rx_bit),
        .rx_code(rx_code), .rx_new(rx_new), .rx_idle(rx_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected word bit k: 0, code MSB first, 0, eight ones.
    function automatic logic exp_bit(input logic [5:0] c, input int k);
        if (k == 0 || k == 7) return 1'b0;
        if (k <= 6) return c[6-k];
        return 1'b1;
    endfunction

    // One strobe: drive rx bit, capture tx bit taken, then rx_new after the edge.
    task automatic strobe(input logic rb, output logic tb, output logic np);
        @(negedge clk);
        frame_stb = 1'b1;
        rx_bit    = rb;
        tb        = tx_bit;
        @(negedge clk);
        frame_stb = 1'b0;
        np        = rx_new;
    endtask

    task automatic rx_word(input logic [5:0] c, output int pulses, output logic last);
        logic tb, np;
        pulses = 0;
        last   = 1'b0;
        for (int k = 0; k < 16; k++) begin
            strobe(exp_bit(c, k), tb, np);
            pulses += int'(np);
            if (k == 15) last = np;
        end
    endtask

    task automatic rx_words(input logic [5:0] c, input int n, output int pulses);
        int p;
        logic l;
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            rx_word(c, p, l);
            pulses += p;
        end
    endtask

    task automatic load_code(input logic [5:0] c);
        @(negedge clk);
        host_code = c;
        host_load = 1'b1;
        @(negedge clk);
        host_load = 1'b0;
    endtask

    // Send one word from the transmitter, counting bit mismatches.
    task automatic tx_word(input logic [5:0] c, output int bad);
        logic tb, np;
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            strobe(1'b1, tb, np);
            if (tb != exp_bit(c, k)) bad++;
        end
    endtask

    task automatic t_reset;
        chk("R1 tx_bit", int'(tx_bit), 1);
        chk("R1 tx_active", int'(tx_active), 0);
        chk("R1 rx_code", int'(rx_code), 0);
        chk("R1 rx_new", int'(rx_new), 0);
        chk("R1 rx_idle", int'(rx_idle), 0);
    endtask

    task automatic t_rx_declare;
        int p;
        logic l;
        rx_words(6'h2A, 4, p);
        chk("R6 four words no pulse", p, 0);
        rx_word(6'h2A, p, l);
        chk("R6 fifth word pulses once", p, 1);
        chk("R6 pulse on last bit", int'(l), 1);
        chk("R6 code taken", int'(rx_code), 'h2A);
        rx_words(6'h2A, 2, p);
        chk("R8 repeats no pulse", p, 0);
        chk("R11 code held", int'(rx_code), 'h2A);
    endtask

    task automatic t_rx_restart;
        int p, q;
        logic l;
        rx_words(6'h15, 3, p);
        rx_words(6'h2A, 1, q);
        p += q;
        rx_words(6'h15, 4, q);
        p += q;
        chk("R7 differing word restarts", p, 0);
        chk("R11 code held over restart", int'(rx_code), 'h2A);
        rx_word(6'h15, p, l);
        chk("R7 fifth after restart", int'(l), 1);
        chk("R7 new code", int'(rx_code), 'h15);
    endtask

    task automatic t_rx_gap;
        int p, q;
        logic l, tb, np;
        rx_words(6'h0C, 4, p);
        for (int i = 0; i < 3; i++) strobe(1'b1, tb, np);
        rx_words(6'h0C, 4, q);
        chk("R7 gap restarts count", p + q, 0);
        rx_word(6'h0C, p, l);
        chk("R7 fifth after gap", int'(l), 1);
        chk("R7 gap code", int'(rx_code), 'h0C);
    endtask

    task automatic t_rx_idle;
        logic tb, np;
        strobe(1'b0, tb, np);
        chk("R9 zero clears", int'(rx_idle), 0);
        for (int i = 0; i < 15; i++) strobe(1'b1, tb, np);
        chk("R9 fifteen ones not idle", int'(rx_idle), 0);
        strobe(1'b1, tb, np);
        chk("R9 sixteenth one idle", int'(rx_idle), 1);
        strobe(1'b0, tb, np);
        chk("R9 zero drops idle", int'(rx_idle), 0);
    endtask

    task automatic t_tx_send;
        logic tb, np;
        int bad;
        load_code(6'h2D);
        strobe(1'b1, tb, np);
        chk("R4 idle bit", int'(tb), 1);
        @(negedge clk);
        host_exec = 1'b1;
        strobe(1'b1, tb, np);
        chk("R4 bit before start", int'(tb), 1);
        chk("R2 active after start", int'(tx_active), 1);
        tx_word(6'h2D, bad);
        chk("R2 first word bits", bad, 0);
        tx_word(6'h2D, bad);
        chk("R3 repeated word bits", bad, 0);
        // third word: load attempt and execute drop mid-word
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            if (k == 4) load_code(6'h11);
            if (k == 5) host_exec = 1'b0;
            strobe(1'b1, tb, np);
            if (tb != exp_bit(6'h2D, k)) bad++;
        end
        chk("R3 word completes after exec drop", bad, 0);
        strobe(1'b1, tb, np);
        chk("R3 ones after end", int'(tb), 1);
        chk("R3 inactive after end", int'(tx_active), 0);
        @(negedge clk);
        host_exec = 1'b1;
        strobe(1'b1, tb, np);
        host_exec = 1'b0;
        tx_word(6'h2D, bad);
        chk("R5 blocked load kept old code", bad, 0);
        load_code(6'h11);
        @(negedge clk);
        host_exec = 1'b1;
        strobe(1'b1, tb, np);
        host_exec = 1'b0;
        tx_word(6'h11, bad);
        chk("R5 idle load takes effect", bad, 0);
        strobe(1'b1, tb, np);
        chk("R4 ones when idle", int'(tb), 1);
    endtask

    task automatic t_mode_off;
        logic tb, np;
        int p;
        @(negedge clk);
        host_exec = 1'b1;
        strobe(1'b1, tb, np);
        strobe(1'b1, tb, np);
        strobe(1'b1, tb, np);
        chk("R10 sending before mode off", int'(tx_active), 1);
        @(negedge clk);
        cbit_mode = 1'b0;
        @(negedge clk);
        chk("R10 mid-word stop", int'(tx_active), 0);
        chk("R10 mid-word ones", int'(tx_bit), 1);
        strobe(1'b1, tb, np);
        chk("R10 tx ones while off", int'(tb), 1);
        rx_words(6'h33, 5, p);
        chk("R10 no declaration while off", p, 0);
        chk("R10 code unchanged", int'(rx_code), 'h0C);
        for (int i = 0; i < 20; i++) strobe(1'b1, tb, np);
        chk("R10 idle held low", int'(rx_idle), 0);
        host_exec = 1'b0;
        cbit_mode = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_declare();
        t_rx_restart();
        t_rx_gap();
        t_rx_idle();
        t_tx_send();
        t_mode_off();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 60000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule